// File: doc/BRIEF.md
# Six-Step Hall Commutator

This block drives a three-phase inverter for a brushless DC motor from two inputs only: the three Hall-effect sensor lines and one switch command bit produced by an external current modulator. It filters the Hall lines, decodes them into one of six electrical sectors and picks the two active phases for that sector. In each sector one phase sources current through its upper switch and one phase sinks it through its lower switch. The third phase stays idle. The command bit switches the whole conduction path on and off, so the inverter behaves as one equivalent buck switch. It never applies a separate duty cycle to each phase.

Each Hall line passes through a two-flop synchroniser and a glitch filter before it is decoded. The all-zero and all-one Hall codes count as sensor faults, and they remove all gate drive. A direction input swaps the source and sink roles, so the motor torque reverses and the sectors step in descending order. Every leg runs its own small state machine. That machine keeps both switches of the leg off for a set number of clock cycles before it turns on the complement of a switch that was just on. It lets the same switch turn back on at once when the command bit chops it.

The sector state machine has the states SEC0 to SEC5 and SEC_FAULT. Its transitions are SECk to SECj on a valid filtered code, any state to SEC_FAULT on code 000 or 111, and SEC_FAULT to SECk when a valid code returns. Each leg state machine has four states:

- LEG_HI: the upper switch is on.
- LEG_LO: the lower switch is on.
- LEG_REST_HI: both switches are off and the upper switch was the last one on.
- LEG_REST_LO: both switches are off and the lower switch was the last one on.

A leg goes from an on state to the matching rest state as soon as its request changes. From a rest state it goes back to the same side at once. It goes to the opposite side only after the dead-time count has run out.

Top module: `sixstep_commutator`

## Requirements
- R1: Filtered Hall code {hall_i[2],hall_i[1],hall_i[0]} selects a sector: 001=SEC0, 011=SEC1, 010=SEC2, 110=SEC3, 100=SEC4, 101=SEC5. In the forward direction with the command high, the sourcing and sinking phases (0=A, 1=B, 2=C; upper gate in gate_hi_o[p], lower in gate_lo_o[p]) are: SEC0 A→B, SEC1 A→C, SEC2 B→C, SEC3 B→A, SEC4 C→A, SEC5 C→B. The third phase has both gates off, and at most two gates are on at any time.
- R2: While pwm_i is low, all six gates turn off. A change on pwm_i reaches the gates one clock later, unless a dead-time wait applies.
- R3: With dir_i high, the phase that would source in the forward table sinks instead, and the phase that would sink sources instead.
- R4: Filtered codes 000 and 111 drive fault_o high and turn all gates off. After reset, fault_o is high and all gates are off until a valid code has been filtered in.
- R5: A change on a Hall line is accepted only after it has held for FILT_CYC consecutive clock cycles. A pulse of FILT_CYC-1 cycles leaves the gates unchanged.
- R6: gate_hi_o[p] and gate_lo_o[p] are never high together.
- R7: Once a switch of a leg has turned off, its complement stays off for at least DEAD_CYC clock cycles. If the opposite side is requested immediately, it turns on after exactly DEAD_CYC off cycles. A switch turned off only by the command bit turns back on one cycle after the command returns, with no dead-time wait.
- R8: As forward sectors advance from SEC0 to SEC5, each leg goes through source, source (while the return leg changes), idle, sink, sink, idle. Leg B follows the same order two sectors later than leg A, and leg C two sectors later than leg B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Raw Hall sensor lines; bit p belongs to phase p |
| dir_i | input | 1 | 0 for forward, 1 to swap source and sink |
| pwm_i | input | 1 | Switch command from the current modulator |
| gate_hi_o | output | 3 | Upper switch gates, one per phase |
| gate_lo_o | output | 3 | Lower switch gates, one per phase |
| fault_o | output | 1 | High while the filtered Hall code is invalid |

## Verification
The bench builds the block with FILT_CYC=5 and DEAD_CYC=3. With these values a sector change settles in under twenty cycles, so many random sector, direction and command combinations fit into a short run. The short windows also let the bench place glitch pulses one cycle shorter than, and exactly as long as, the filter length. It can also count the off cycles of a direction flip one by one. A random chopping phase then toggles the command every cycle while sectors and direction jump at random. This phase tests the two rules that every chip must keep: no leg ever has both switches on, and no complement turns on early.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    typedef enum logic [2:0] {
        SEC0, SEC1, SEC2, SEC3, SEC4, SEC5, SEC_FAULT
    } sector_e;

    typedef enum logic [1:0] {
        REQ_OFF, REQ_HI, REQ_LO
    } leg_req_e;

    typedef enum logic [1:0] {
        LEG_REST_HI, LEG_REST_LO, LEG_HI, LEG_LO
    } leg_state_e;

    localparam int NUM_PHASES = 3;

endpackage

// File: rtl/hall_filter.sv
module hall_filter #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int FW = $clog2(FILT_CYC + 1);

    logic          meta_q, sync_q;
    logic [FW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Count how long the synchronised value has differed from the accepted one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_o <= 1'b0;
        end else if (sync_q == clean_o) begin
            run_q <= '0;
        end else if (run_q == FW'(FILT_CYC - 1)) begin
            run_q   <= '0;
            clean_o <= sync_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_o) |-> (clean_o == $past(sync_q)));

endmodule

// File: rtl/sector_fsm.sv
module sector_fsm
    import sixstep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic [2:0] code_i,
    input  logic     dir_i,
    input  logic     pwm_i,
    output leg_req_e req_o [NUM_PHASES],
    output logic     fault_o
);
    sector_e state_q, state_d;
    logic [1:0] src, snk;

    always_comb begin
        unique case (code_i)
            3'b001:  state_d = SEC0;
            3'b011:  state_d = SEC1;
            3'b010:  state_d = SEC2;
            3'b110:  state_d = SEC3;
            3'b100:  state_d = SEC4;
            3'b101:  state_d = SEC5;
            default: state_d = SEC_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEC_FAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        src = 2'd0;
        snk = 2'd0;
        unique case (state_q)
            SEC0:      begin src = 2'd0; snk = 2'd1; end
            SEC1:      begin src = 2'd0; snk = 2'd2; end
            SEC2:      begin src = 2'd1; snk = 2'd2; end
            SEC3:      begin src = 2'd1; snk = 2'd0; end
            SEC4:      begin src = 2'd2; snk = 2'd0; end
            SEC5:      begin src = 2'd2; snk = 2'd1; end
            SEC_FAULT: begin src = 2'd0; snk = 2'd0; end
            default:   begin src = 2'd0; snk = 2'd0; end
        endcase
        for (int p = 0; p < NUM_PHASES; p++) req_o[p] = REQ_OFF;
        if (state_q != SEC_FAULT && pwm_i) begin
            if (dir_i) begin
                req_o[src] = REQ_LO;
                req_o[snk] = REQ_HI;
            end else begin
                req_o[src] = REQ_HI;
                req_o[snk] = REQ_LO;
            end
        end
    end

    assign fault_o = (state_q == SEC_FAULT);

    // R4
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 3'b000 || code_i == 3'b111) |=> fault_o);

endmodule

// File: rtl/dead_leg.sv
module dead_leg
    import sixstep_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req_i,
    output logic     hi_o,
    output logic     lo_o
);
    localparam int DW = $clog2(DEAD_CYC + 1) + 1;

    leg_state_e    state_q, state_d;
    logic [DW-1:0] gap_q;
    logic          gap_done, resting, leaving_on;

    assign gap_done = (gap_q >= DW'(DEAD_CYC));
    assign resting  = (state_q == LEG_REST_HI) || (state_q == LEG_REST_LO);
    assign leaving_on = !resting &&
                        ((state_d == LEG_REST_HI) || (state_d == LEG_REST_LO));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_HI:      if (req_i != REQ_HI) state_d = LEG_REST_HI;
            LEG_LO:      if (req_i != REQ_LO) state_d = LEG_REST_LO;
            LEG_REST_HI: begin
                if (req_i == REQ_HI)                  state_d = LEG_HI;
                else if (req_i == REQ_LO && gap_done) state_d = LEG_LO;
            end
            LEG_REST_LO: begin
                if (req_i == REQ_LO)                  state_d = LEG_LO;
                else if (req_i == REQ_HI && gap_done) state_d = LEG_HI;
            end
            default:     state_d = LEG_REST_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_REST_LO;
            gap_q   <= DW'(DEAD_CYC);
        end else begin
            state_q <= state_d;
            if (leaving_on)
                gap_q <= DW'(1);
            else if (resting && !gap_done)
                gap_q <= gap_q + 1'b1;
        end
    end

    always_comb begin
        hi_o = (state_q == LEG_HI);
        lo_o = (state_q == LEG_LO);
    end

    // R6
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    // R7
    lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_o) |-> !$past(hi_o));

    // R7
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_o) |-> !$past(lo_o));

endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
    import sixstep_pkg::*;
#(
    parameter int FILT_CYC = 16,
    parameter int DEAD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    input  logic       pwm_i,
    output logic [2:0] gate_hi_o,
    output logic [2:0] gate_lo_o,
    output logic       fault_o
);
    logic [2:0] code;
    leg_req_e   req [NUM_PHASES];

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_hall
        hall_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (hall_i[p]),
            .clean_o (code[p])
        );
    end

    sector_fsm u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (code),
        .dir_i   (dir_i),
        .pwm_i   (pwm_i),
        .req_o   (req),
        .fault_o (fault_o)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        dead_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req[p]),
            .hi_o  (gate_hi_o[p]),
            .lo_o  (gate_lo_o[p])
        );
    end

    // R1
    two_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gate_hi_o, gate_lo_o}) <= 2);

    // R4
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && $past(fault_o)) |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

    // R2
    pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pwm_i) |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

endmodule

// File: tb/sim_sixstep_commutator.sv
module sim_sixstep_commutator;

    localparam int FILT = 5;
    localparam int DEAD = 3;
    localparam int SETTLE = FILT + DEAD + 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b000;
    logic       dir_i = 1'b0;
    logic       pwm_i = 1'b0;
    logic [2:0] gate_hi_o, gate_lo_o;
    logic       fault_o;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;

    always #4 clk = ~clk;

    sixstep_commutator #(.FILT_CYC(FILT), .DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_i(dir_i), .pwm_i(pwm_i),
        .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .fault_o(fault_o)
    );

    function automatic logic [2:0] code_of(int s);
        case (s)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b010;
            3: return 3'b110;
            4: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    // {fault, hi[2:0], lo[2:0]} expected from the sector table
    function automatic logic [6:0] expect_out(int s, bit dir, bit pwm, bit flt);
        int src, snk, t;
        logic [2:0] hi, lo;
        if (flt) return 7'b1_000_000;
        if (!pwm) return 7'b0;
        case (s)
            0: begin src = 0; snk = 1; end
            1: begin src = 0; snk = 2; end
            2: begin src = 1; snk = 2; end
            3: begin src = 1; snk = 0; end
            4: begin src = 2; snk = 0; end
            default: begin src = 2; snk = 1; end
        endcase
        if (dir) begin t = src; src = snk; snk = t; end
        hi = 3'b000; lo = 3'b000;
        hi[src] = 1'b1;
        lo[snk] = 1'b1;
        return {1'b0, hi, lo};
    endfunction

    function automatic logic [6:0] observed();
        return {fault_o, gate_hi_o, gate_lo_o};
    endfunction

    task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go(int s, bit dir, bit pwm);
        hall_i = code_of(s);
        dir_i = dir;
        pwm_i = pwm;
        cycles(SETTLE);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Safety monitor for R6 and R7
    int since_hi [3] = '{100, 100, 100};
    int since_lo [3] = '{100, 100, 100};
    logic [2:0] prev_hi = 3'b000, prev_lo = 3'b000;
    int mon_bad = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            for (int p = 0; p < 3; p++) begin
                if (gate_hi_o[p] && gate_lo_o[p]) begin
                    mon_bad++; n_fail++;
                    $display("FAIL R6 leg %0d actual=both_on expected=exclusive", p);
                end
                if (gate_hi_o[p] && !prev_hi[p] && since_lo[p] < DEAD) begin
                    mon_bad++; n_fail++;
                    $display("FAIL R7 leg %0d upper on after gap actual=%0d expected>=%0d",
                             p, since_lo[p], DEAD);
                end
                if (gate_lo_o[p] && !prev_lo[p] && since_hi[p] < DEAD) begin
                    mon_bad++; n_fail++;
                    $display("FAIL R7 leg %0d lower on after gap actual=%0d expected>=%0d",
                             p, since_hi[p], DEAD);
                end
                since_hi[p] = gate_hi_o[p] ? 0 : (since_hi[p] < 100 ? since_hi[p] + 1 : 100);
                since_lo[p] = gate_lo_o[p] ? 0 : (since_lo[p] < 100 ? since_lo[p] + 1 : 100);
            end
            prev_hi = gate_hi_o;
            prev_lo = gate_lo_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        cycles(3);
        // R4 reset state
        chk("R4 reset", observed(), 7'b1_000_000);
        rst_n = 1'b1;
        mon_en = 1'b1;
        cycles(2);
        chk("R4 after release", observed(), 7'b1_000_000);

        // R8 forward sweep, R1 table
        for (int s = 0; s < 6; s++) begin
            go(s, 1'b0, 1'b1);
            chk($sformatf("R8 R1 forward sector %0d", s), observed(), expect_out(s, 0, 1, 0));
        end
        // R3 reverse sweep
        for (int s = 5; s >= 0; s--) begin
            go(s, 1'b1, 1'b1);
            chk($sformatf("R3 reverse sector %0d", s), observed(), expect_out(s, 1, 1, 0));
        end

        // R4 invalid codes
        hall_i = 3'b000; cycles(SETTLE);
        chk("R4 code 000", observed(), 7'b1_000_000);
        go(1, 1'b0, 1'b1);
        chk("R4 recovery", observed(), expect_out(1, 0, 1, 0));
        hall_i = 3'b111; cycles(SETTLE);
        chk("R4 code 111", observed(), 7'b1_000_000);

        // R2 command low
        go(4, 1'b0, 1'b0);
        chk("R2 pwm low", observed(), 7'b0);

        // R7 chop: re-on one cycle after command returns
        go(2, 1'b0, 1'b1);
        pwm_i = 1'b0;
        @(negedge clk);
        chk("R2 off one cycle later", observed(), 7'b0);
        pwm_i = 1'b1;
        @(negedge clk);
        chk("R7 chop re-on immediate", observed(), expect_out(2, 0, 1, 0));

        // R7 exact dead time on direction flip
        go(0, 1'b0, 1'b1);
        dir_i = 1'b1;
        begin
            logic [6:0] worst;
            worst = 7'b0;
            for (int k = 0; k < DEAD; k++) begin
                @(negedge clk);
                worst = worst | observed();
            end
            chk("R7 gap all off", worst, 7'b0);
        end
        @(negedge clk);
        chk("R7 complement on after gap", observed(), expect_out(0, 1, 1, 0));

        // R5 glitch shorter than filter
        go(0, 1'b0, 1'b1);
        begin
            logic [6:0] diff;
            diff = 7'b0;
            hall_i = code_of(1);
            cycles(FILT - 1);
            hall_i = code_of(0);
            for (int k = 0; k < SETTLE; k++) begin
                @(negedge clk);
                diff = diff | (observed() ^ expect_out(0, 0, 1, 0));
            end
            chk("R5 short pulse ignored", diff, 7'b0);
        end
        // R5 pulse of exactly the filter length is taken
        begin
            bit seen;
            seen = 1'b0;
            hall_i = code_of(1);
            cycles(FILT);
            hall_i = code_of(0);
            for (int k = 0; k < SETTLE; k++) begin
                @(negedge clk);
                if (observed() == expect_out(1, 0, 1, 0)) seen = 1'b1;
            end
            chk("R5 full pulse accepted", {6'b0, seen}, 7'b1);
        end

        // Random directed settles
        for (int i = 0; i < 40; i++) begin
            int s;
            bit d, w;
            s = int'($urandom % 6);
            d = 1'($urandom % 2);
            w = ($urandom % 4) != 0;
            go(s, d, w);
            chk($sformatf("R1 R2 R3 random %0d", i), observed(), expect_out(s, d, w, 0));
        end

        // Random chopping with sector and direction jumps; monitor covers R6 R7
        for (int i = 0; i < 2000; i++) begin
            pwm_i = 1'($urandom % 2);
            if ($urandom % 23 == 0) hall_i = code_of(int'($urandom % 6));
            if ($urandom % 97 == 0) dir_i = ~dir_i;
            @(negedge clk);
        end
        pwm_i = 1'b1;
        cycles(SETTLE);
        n_chk++;
        if (mon_bad != 0)
            $display("FAIL R6 R7 monitor actual=%0d expected=0", mon_bad);

        finish_up();
    end

endmodule